// File: doc/BRIEF.md
# Colour Palette Lookup Port

This block holds a colour lookup table of 256 RGB entries, 8 bits per component. A host reaches it through one 32-bit register, where each byte lane has its own job. One lane sets the entry that the next writes go to. One lane sets the entry that the next reads come from. One lane holds a mask that is applied to written colour bytes. The last lane is a data port that carries one colour component at a time.

A colour entry moves through the data lane as three accesses in a row, red first, then green, then blue. A shared component counter keeps track of the position and stages the bytes in a three-slot buffer. After the third access, the index in use moves on by one. A separate display port returns the full entry for any pixel index, one cycle after the index is presented. The display port never disturbs the host-side sequence.

Top module: `palette_dac_port`

## Requirements
- R1: After reset the write index and read index are 0, the pixel mask is 0xFF, the component counter is 0 and every palette entry is 0.
- R2: A host read returns its word on `hostRdData` in the cycle after the read strobe. The lane layout is: bits 7:0 write index, bits 15:8 colour component, bits 23:16 pixel mask, bits 31:24 read index. Lanes that are not enabled read as zero, and `hostRdData` is zero in every cycle that follows a cycle without a read.
- R3: A write that enables lane 0 loads the write index from bits 7:0. A write that enables lane 3 loads the read index from bits 31:24. Either load resets the component counter to 0. In such a write the data lane is ignored.
- R4: A data write (lane 1 enabled, lanes 0 and 3 not enabled) puts bits 15:8 ANDed with the pixel mask into the buffer slot for the current count, then advances the counter. The mask used is the one in force before the access. A write to lane 2 sets the mask.
- R5: On the third data write, the entry at the write index becomes {red, green, blue}, the write index increments (255 wraps to 0) and the counter returns to 0.
- R6: A data read with the counter at 0 fetches the entry at the read index into the buffer and returns red. The following data reads return green, then blue, from the buffer.
- R7: After the third data read the read index increments (255 wraps to 0) and the counter returns to 0.
- R8: An access that does not enable lane 1 leaves the component counter unchanged. This covers mask writes and reads of the index or mask lanes.
- R9: `pixRgb` presents the entry at `pixIdx` one cycle later, with red in bits 23:16, green in bits 15:8 and blue in bits 7:0.
- R10: When a read and a write are strobed in the same cycle, the write is carried out and the read is dropped, so `hostRdData` reads as zero next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWrEn | input | 1 | Host write strobe |
| hostRdEn | input | 1 | Host read strobe |
| hostByteEn | input | 4 | Byte lane enables for the access |
| hostWrData | input | 32 | Host write word |
| hostRdData | output | 32 | Host read word, registered |
| pixIdx | input | IDX_W | Display-side palette index |
| pixRgb | output | 24 | Display-side colour entry, registered |

## Verification
The bench keeps the default IDX_W of 8, so it covers the full 256-entry table. It writes all 768 components, reads every one back through the data lane, and checks every entry through the display port. This also takes both indices through their wrap from 255 to 0. Directed sequences then cover several cases: masked writes, index reloads in the middle of a triplet, accesses that skip the data lane, a combined read-and-write strobe, and a data byte sent alongside an index load.

// File: rtl/palette_dac_pkg.sv
package palette_dac_pkg;

  localparam int LANE_W   = 8;
  localparam int COMP_CNT = 3;
  localparam int ENTRY_W  = LANE_W * COMP_CNT;

  localparam int LANE_WR_IDX = 0;
  localparam int LANE_DATA   = 1;
  localparam int LANE_MASK   = 2;
  localparam int LANE_RD_IDX = 3;

  // Strobes from the control unit to the datapath
  typedef struct packed {
    logic              storeComp;   // place compByte into slot compSel
    logic              commitEntry; // write buffer + compByte into palette
    logic              fetchEntry;  // load the whole entry into the buffer
    logic              readComp;    // a data-lane read is in progress
    logic [1:0]        compSel;     // current component slot
    logic [LANE_W-1:0] entryIdx;    // palette index for commit or fetch
    logic [LANE_W-1:0] compByte;    // masked write byte
  } dac_strobe_t;

endpackage

// File: rtl/palette_dac_ctrl.sv
module palette_dac_ctrl
  import palette_dac_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWrEn,
  input  logic              hostRdEn,
  input  logic [3:0]        hostByteEn,
  input  logic [31:0]       hostWrData,
  output dac_strobe_t       strb,
  output logic [IDX_W-1:0]  wrIdx,
  output logic [IDX_W-1:0]  rdIdx,
  output logic [LANE_W-1:0] pixMask
);

  localparam logic [1:0] LAST_COMP = 2'(COMP_CNT - 1);

  logic [1:0] compCnt;
  logic       wrAccess;
  logic       rdAccess;
  logic       idxLoad;
  logic       dataWr;
  logic       dataRd;
  logic       lastComp;

  assign wrAccess = hostWrEn;
  assign rdAccess = hostRdEn & ~hostWrEn;
  assign idxLoad  = wrAccess & (hostByteEn[LANE_WR_IDX] | hostByteEn[LANE_RD_IDX]);
  assign dataWr   = wrAccess & hostByteEn[LANE_DATA] & ~idxLoad;
  assign dataRd   = rdAccess & hostByteEn[LANE_DATA];
  assign lastComp = (compCnt == LAST_COMP);

  always_comb begin
    strb             = '0;
    strb.storeComp   = dataWr;
    strb.commitEntry = dataWr & lastComp;
    strb.fetchEntry  = dataRd & (compCnt == 2'd0);
    strb.readComp    = dataRd;
    strb.compSel     = compCnt;
    strb.entryIdx[IDX_W-1:0] = dataRd ? rdIdx : wrIdx;
    strb.compByte    = hostWrData[LANE_DATA*LANE_W +: LANE_W] & pixMask;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      compCnt <= '0;
      wrIdx   <= '0;
      rdIdx   <= '0;
    end else if (idxLoad) begin
      if (hostByteEn[LANE_WR_IDX]) wrIdx <= hostWrData[LANE_WR_IDX*LANE_W +: IDX_W];
      if (hostByteEn[LANE_RD_IDX]) rdIdx <= hostWrData[LANE_RD_IDX*LANE_W +: IDX_W];
      compCnt <= '0;
    end else if (dataWr) begin
      if (lastComp) begin
        compCnt <= '0;
        wrIdx   <= wrIdx + 1'b1;
      end else begin
        compCnt <= compCnt + 1'b1;
      end
    end else if (dataRd) begin
      if (lastComp) begin
        compCnt <= '0;
        rdIdx   <= rdIdx + 1'b1;
      end else begin
        compCnt <= compCnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pixMask <= '1;
    end else if (wrAccess && hostByteEn[LANE_MASK]) begin
      pixMask <= hostWrData[LANE_MASK*LANE_W +: LANE_W];
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    compCnt != 2'd3); // R4
  AST_IDX_LOAD_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (hostWrEn && (hostByteEn[LANE_WR_IDX] || hostByteEn[LANE_RD_IDX])) |=> compCnt == 2'd0); // R3
  AST_WR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    strb.commitEntry |=> wrIdx == IDX_W'($past(wrIdx) + 1'b1)); // R5
  AST_RD_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (dataRd && lastComp) |=> (rdIdx == IDX_W'($past(rdIdx) + 1'b1)) && (compCnt == 2'd0)); // R7
  AST_NO_LANE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    ((hostWrEn || hostRdEn) && !hostByteEn[LANE_DATA] && !hostByteEn[LANE_WR_IDX] && !hostByteEn[LANE_RD_IDX])
      |=> $stable(compCnt)); // R8
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(hostWrEn && hostByteEn[LANE_MASK]) |=> $stable(pixMask)); // R4

endmodule

// File: rtl/palette_dac_datapath.sv
module palette_dac_datapath
  import palette_dac_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  dac_strobe_t        strb,
  input  logic               rdReq,
  input  logic [3:0]         hostByteEn,
  input  logic [IDX_W-1:0]   wrIdx,
  input  logic [IDX_W-1:0]   rdIdx,
  input  logic [LANE_W-1:0]  pixMask,
  input  logic [IDX_W-1:0]   pixIdx,
  output logic [31:0]        hostRdData,
  output logic [ENTRY_W-1:0] pixRgb
);

  localparam int ENTRIES = 1 << IDX_W;

  logic [ENTRY_W-1:0] palette [ENTRIES];
  logic [LANE_W-1:0]  compBuf [COMP_CNT];
  logic [IDX_W-1:0]   accIdx;
  logic [ENTRY_W-1:0] accEntry;
  logic [LANE_W-1:0]  bufByte;
  logic [LANE_W-1:0]  readByte;
  logic [31:0]        rdWord;

  assign accIdx   = strb.entryIdx[IDX_W-1:0];
  assign accEntry = palette[accIdx];

  // Component slots; slot 0 is red and sits in the top byte of an entry
  for (genvar g = 0; g < COMP_CNT; g++) begin : gSlot
    always_ff @(posedge clk) begin
      if (!rstN) begin
        compBuf[g] <= '0;
      end else if (strb.fetchEntry) begin
        compBuf[g] <= accEntry[(COMP_CNT-1-g)*LANE_W +: LANE_W];
      end else if (strb.storeComp && (strb.compSel == 2'(g))) begin
        compBuf[g] <= strb.compByte;
      end
    end
  end

  always_comb begin
    case (strb.compSel)
      2'd0:    bufByte = compBuf[0];
      2'd1:    bufByte = compBuf[1];
      default: bufByte = compBuf[2];
    endcase
  end

  assign readByte = strb.fetchEntry ? accEntry[ENTRY_W-1 -: LANE_W] : bufByte;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) palette[i] <= '0;
    end else if (strb.commitEntry) begin
      palette[accIdx] <= {compBuf[0], compBuf[1], strb.compByte};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) pixRgb <= '0;
    else       pixRgb <= palette[pixIdx];
  end

  always_comb begin
    rdWord = '0;
    if (hostByteEn[LANE_WR_IDX]) rdWord[LANE_WR_IDX*LANE_W +: LANE_W] = LANE_W'(wrIdx);
    if (hostByteEn[LANE_DATA])   rdWord[LANE_DATA*LANE_W   +: LANE_W] = readByte;
    if (hostByteEn[LANE_MASK])   rdWord[LANE_MASK*LANE_W   +: LANE_W] = pixMask;
    if (hostByteEn[LANE_RD_IDX]) rdWord[LANE_RD_IDX*LANE_W +: LANE_W] = LANE_W'(rdIdx);
  end

  always_ff @(posedge clk) begin
    if (!rstN)      hostRdData <= '0;
    else if (rdReq) hostRdData <= rdWord;
    else            hostRdData <= '0;
  end

  AST_COMMIT_LAST_SLOT: assert property (@(posedge clk) disable iff (!rstN)
    strb.commitEntry |-> (strb.storeComp && strb.compSel == 2'd2)); // R5
  AST_FETCH_FIRST_SLOT: assert property (@(posedge clk) disable iff (!rstN)
    strb.fetchEntry |-> (strb.readComp && strb.compSel == 2'd0)); // R6
  AST_NO_STORE_ON_READ: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.storeComp && strb.readComp)); // R10
  AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !rdReq |=> hostRdData == '0); // R2

endmodule

// File: rtl/palette_dac_port.sv
module palette_dac_port
  import palette_dac_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hostWrEn,
  input  logic               hostRdEn,
  input  logic [3:0]         hostByteEn,
  input  logic [31:0]        hostWrData,
  output logic [31:0]        hostRdData,
  input  logic [IDX_W-1:0]   pixIdx,
  output logic [ENTRY_W-1:0] pixRgb
);

  dac_strobe_t       strb;
  logic [IDX_W-1:0]  wrIdx;
  logic [IDX_W-1:0]  rdIdx;
  logic [LANE_W-1:0] pixMask;
  logic              rdReq;

  assign rdReq = hostRdEn & ~hostWrEn;

  palette_dac_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .hostWrEn   (hostWrEn),
    .hostRdEn   (hostRdEn),
    .hostByteEn (hostByteEn),
    .hostWrData (hostWrData),
    .strb       (strb),
    .wrIdx      (wrIdx),
    .rdIdx      (rdIdx),
    .pixMask    (pixMask)
  );

  palette_dac_datapath #(.IDX_W(IDX_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .rdReq      (rdReq),
    .hostByteEn (hostByteEn),
    .wrIdx      (wrIdx),
    .rdIdx      (rdIdx),
    .pixMask    (pixMask),
    .pixIdx     (pixIdx),
    .hostRdData (hostRdData),
    .pixRgb     (pixRgb)
  );

endmodule

// File: tb/palette_dac_port_bench.sv
module palette_dac_port_bench;

  localparam int IDX_W = 8;
  localparam int N     = 1 << IDX_W;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostWrEn = 1'b0;
  logic        hostRdEn = 1'b0;
  logic [3:0]  hostByteEn = '0;
  logic [31:0] hostWrData = '0;
  logic [31:0] hostRdData;
  logic [IDX_W-1:0] pixIdx = '0;
  logic [23:0] pixRgb;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  palette_dac_port #(.IDX_W(IDX_W)) u_palette_dac_port (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostRdEn(hostRdEn),
    .hostByteEn(hostByteEn), .hostWrData(hostWrData), .hostRdData(hostRdData),
    .pixIdx(pixIdx), .pixRgb(pixRgb)
  );

  function automatic logic [7:0] pat(input int i, input int c);
    return 8'((i * 7 + c * 85 + 3) & 8'hFF);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic hostWrite(input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    hostWrEn = 1'b1; hostByteEn = be; hostWrData = d;
    @(negedge clk);
    hostWrEn = 1'b0; hostByteEn = '0; hostWrData = '0;
  endtask

  task automatic hostRead(input logic [3:0] be, output logic [31:0] d);
    @(negedge clk);
    hostRdEn = 1'b1; hostByteEn = be;
    @(negedge clk);
    d = hostRdData;
    hostRdEn = 1'b0; hostByteEn = '0;
  endtask

  task automatic pixCheck(input string tag, input int idx, input logic [23:0] exp);
    @(negedge clk);
    pixIdx = IDX_W'(idx);
    @(negedge clk);
    chk(tag, {8'h0, pixRgb}, {8'h0, exp});
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(10 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state, read without the data lane
    chk("R2 idle read data zero", hostRdData, 32'h0);
    hostRead(4'b1101, rd);
    chk("R1 reset indices and mask", rd, 32'h00FF_0000);
    pixCheck("R1 reset palette entry 0", 0, 24'h0);
    pixCheck("R1 reset palette entry 255", 255, 24'h0);
    @(negedge clk);
    chk("R2 zero after read cycle", hostRdData, 32'h0);

    // R5: full write sweep, wraps the write index
    hostWrite(4'b0001, 32'h0);
    for (int i = 0; i < N; i++)
      for (int c = 0; c < 3; c++)
        hostWrite(4'b0010, {16'h0, pat(i, c), 8'h0});
    hostRead(4'b0001, rd);
    chk("R5 write index wrapped", rd, 32'h0);

    // R9: display port over every entry
    for (int i = 0; i < N; i++)
      pixCheck("R9 display entry", i, {pat(i, 0), pat(i, 1), pat(i, 2)});

    // R6 R7: full read sweep, wraps the read index
    hostWrite(4'b1000, 32'h0);
    for (int i = 0; i < N; i++)
      for (int c = 0; c < 3; c++) begin
        hostRead(4'b0010, rd);
        chk("R6 data read component", rd, {16'h0, pat(i, c), 8'h0});
      end
    hostRead(4'b1000, rd);
    chk("R7 read index wrapped", rd, 32'h0);

    // R4: masked writes
    hostWrite(4'b0100, 32'h000F_0000);
    hostRead(4'b0100, rd);
    chk("R4 mask readback", rd, 32'h000F_0000);
    hostWrite(4'b0001, 32'd5);
    hostWrite(4'b0010, 32'h0000_AB00);
    hostWrite(4'b0010, 32'h0000_CD00);
    hostWrite(4'b0010, 32'h0000_EF00);
    pixCheck("R4 masked entry", 5, 24'h0B0D0F);
    hostRead(4'b0001, rd);
    chk("R5 write index stepped", rd, 32'd6);
    hostWrite(4'b0100, 32'h00FF_0000);

    // R3: index reload mid-triplet resets the counter
    hostWrite(4'b0001, 32'd10);
    hostWrite(4'b0010, 32'h0000_7700);
    hostWrite(4'b0010, 32'h0000_8800);
    hostWrite(4'b0001, 32'd20);
    hostWrite(4'b0010, 32'h0000_1100);
    hostWrite(4'b0010, 32'h0000_2200);
    hostWrite(4'b0010, 32'h0000_3300);
    pixCheck("R3 reloaded entry", 20, 24'h112233);
    pixCheck("R3 abandoned entry kept", 10, {pat(10, 0), pat(10, 1), pat(10, 2)});
    hostRead(4'b0001, rd);
    chk("R3 write index after reload", rd, 32'd21);

    // R3: data byte beside an index load is ignored
    hostWrite(4'b0011, 32'h0000_991E);
    hostWrite(4'b0010, 32'h0000_0100);
    hostWrite(4'b0010, 32'h0000_0200);
    hostWrite(4'b0010, 32'h0000_0300);
    pixCheck("R3 data lane ignored with load", 30, 24'h010203);

    // R8: accesses without the data lane keep the count
    hostWrite(4'b0001, 32'd40);
    hostWrite(4'b0010, 32'h0000_4400);
    hostWrite(4'b0100, 32'h00FF_0000);
    hostRead(4'b1001, rd);
    chk("R8 index read mid-triplet", rd, 32'h0000_0029 - 32'd1);
    hostWrite(4'b0010, 32'h0000_5500);
    hostWrite(4'b0010, 32'h0000_6600);
    pixCheck("R8 counter held across other lanes", 40, 24'h445566);

    // R6: read after reload, and reload mid read triplet
    hostWrite(4'b1000, 32'd5 << 24);
    hostRead(4'b0010, rd);
    chk("R6 first component of entry 5", rd, 32'h0000_0B00);
    hostWrite(4'b1000, 32'd20 << 24);
    hostRead(4'b0010, rd);
    chk("R6 red after read reload", rd, 32'h0000_1100);
    hostRead(4'b0010, rd);
    chk("R6 green", rd, 32'h0000_2200);
    hostRead(4'b0010, rd);
    chk("R6 blue", rd, 32'h0000_3300);
    hostRead(4'b1000, rd);
    chk("R7 read index stepped", rd, 32'd21 << 24);

    // R10: simultaneous strobes, write wins
    @(negedge clk);
    hostWrEn = 1'b1; hostRdEn = 1'b1; hostByteEn = 4'b0001; hostWrData = 32'd50;
    @(negedge clk);
    hostWrEn = 1'b0; hostRdEn = 1'b0; hostByteEn = '0; hostWrData = '0;
    chk("R10 read dropped", hostRdData, 32'h0);
    hostRead(4'b0001, rd);
    chk("R10 write carried out", rd, 32'd50);

    finish_run();
  end

endmodule